// File: doc/BRIEF.md
# Video Processor Control Port Decoder

This block sits between a host bus and the configuration state of a tile-based video processor. It receives 16-bit words on a control port and sorts each one into one of two kinds. A word can be a direct write to one of the internal 8-bit registers. It can also be one half of a two-word command that sets up a 16-bit access address and a 6-bit access code. The access code selects the target memory (pattern memory, colour memory or vertical-scroll memory), the direction, and whether a block transfer should begin.

A data port then carries 16-bit or 32-bit host accesses to an external memory interface. Each access uses the even form of the current address. After each 16-bit beat the address moves on by the programmable step register. Beats that fall outside the selected memory are dropped on writes and return zero on reads. When a command asks for a block transfer and transfers are enabled, the block sends a one-cycle start request to a separate transfer engine. For fill transfers, it first waits for the next data-port write, which supplies the fill word. A read on the control port returns a 10-bit status word assembled from flags that are supplied from outside.

Top module: `vctl_port`

## Requirements
- R1: A control word whose bits 15:13 are 3'b100, arriving while no second word is pending, stores bits 7:0 into the register numbered by bits 12:8. Register 15 is the address step, register 1 bit 4 enables transfers, registers 19/20 hold the transfer length (low/high byte), and registers 21/22/23 hold the source address (low/mid/high, where the high register supplies bits 21:16 from its bits 5:0 and the transfer mode from its bits 7:6).
- R2: Any other control word, arriving while no second word is pending, loads address bits 13:0 from its bits 13:0 and clears address bits 15:14. It loads access-code bits 1:0 from its bits 15:14 and clears code bits 5:2. It also marks a second word as pending.
- R3: While a second word is pending, the next control word is never treated as a register write. It ORs its bits 1:0 into address bits 15:14 and its bits 7:4 into code bits 5:2, then clears the pending mark.
- R4: A second word raises `dma_req` for exactly the following cycle only if transfers are enabled and code bits 5:4 are nonzero. In that case `dma_dst` is the completed address, `dma_code` is the completed code, and `dma_len` and `dma_src` are the register values.
- R5: The transfer mode is taken from source-high bits 7:6. Values 0 and 1 give `dma_kind` 0 (memory to pattern memory) and value 3 gives `dma_kind` 2 (copy). Value 2 gives no request at once; instead it arms a fill. The next data-port write then raises `dma_req` with `dma_kind` 1, `dma_fill` set to the written low half and `dma_dst` set to the current address. That write performs no memory write and does not move the address.
- R6: Code bits 3:0 select the target: 1 is pattern write, 0 is pattern read, 3 is colour write, 8 is colour read, 5 is vertical-scroll write and 4 is vertical-scroll read. On `mem_sel`, the targets are encoded as 0 for pattern, 1 for colour and 2 for vertical-scroll. A data write causes `mem_we` in the next cycle, with `mem_addr` equal to the address with bit 0 cleared. The address then advances by the step register.
- R7: A 16-bit data read asserts `mem_re` in the next cycle. One cycle after that, it presents the memory word on `dat_rdata[15:0]` together with `dat_rvalid`.
- R8: A 32-bit access performs two beats on consecutive cycles, upper half first, and `port_busy` is high for the cycle between the two beats. A 32-bit read returns the first beat in `dat_rdata[31:16]`.
- R9: A beat whose even address is at or beyond the size of the selected memory produces no memory strobe. A read beat of this kind returns zero. The address still advances.
- R10: A data write while the code selects a read, or a data read while the code selects a write, produces no strobe and no read data, and leaves the address unchanged.
- R11: A control-port read makes `ctl_rdata` equal to `stat_flags` in bits 9:0, with bits 15:10 zero, from the next cycle on.
- R12: After reset, all registers, the address, the code, the pending mark and the fill arming are zero, and no strobe or request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_rd | input | 1 | Control port (status) read strobe |
| ctl_wdata | input | 16 | Control word |
| ctl_rdata | output | 16 | Registered status word |
| stat_flags | input | 10 | Status flags, bit 9 FIFO empty down to bit 0 PAL mode |
| dat_wr | input | 1 | Data port write strobe |
| dat_rd | input | 1 | Data port read strobe |
| dat_wide | input | 1 | Access is 32 bits (two beats) |
| dat_wdata | input | 32 | Data write value (16-bit accesses use bits 15:0) |
| dat_rdata | output | 32 | Data read result |
| dat_rvalid | output | 1 | Read result valid pulse |
| port_busy | output | 1 | Second beat of a 32-bit access pending |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_sel | output | 2 | Target memory (0 pattern, 1 colour, 2 vertical-scroll) |
| mem_addr | output | 16 | Even byte address of the beat |
| mem_wdata | output | 16 | Beat write data |
| mem_rdata | input | 16 | Memory read data, valid in the `mem_re` cycle |
| dma_req | output | 1 | Transfer start pulse |
| dma_kind | output | 2 | 0 memory copy-in, 1 fill, 2 copy |
| dma_dst | output | 16 | Transfer destination address |
| dma_code | output | 6 | Access code of the transfer |
| dma_len | output | 16 | Transfer length |
| dma_src | output | 22 | Transfer source address |
| dma_fill | output | 16 | Fill word |

## Verification
A corrupted address or code register shows up at `mem_addr` or `mem_sel` on the very next data-port beat. A step register holding the wrong value shows up one beat later, as the wrong spacing between consecutive addresses. A pending mark stuck in either state makes the following control word be taken as the wrong kind. This is seen within two control writes, either as a missing address high part or as a register write that changes the step. A stuck fill arming shows up on the next data write, either as a missing `mem_we` or as a missing `dma_req`.

// File: rtl/vctl_pkg.sv
package vctl_pkg;

   typedef enum logic [1:0] {
      TGT_PAT   = 2'd0,
      TGT_COL   = 2'd1,
      TGT_VSC   = 2'd2,
      TGT_NONE  = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      DK_MEM  = 2'd0,
      DK_FILL = 2'd1,
      DK_COPY = 2'd2,
      DK_RSVD = 2'd3
   } dkind_e;

   typedef struct packed {
      logic valid;
      logic wr;
      tgt_e tgt;
   } acc_t;

   // register numbers decoded by software
   localparam int RIX_MODE2   = 1;
   localparam int RIX_STEP    = 15;
   localparam int RIX_LEN_LO  = 19;
   localparam int RIX_LEN_HI  = 20;
   localparam int RIX_SRC_LO  = 21;
   localparam int RIX_SRC_MID = 22;
   localparam int RIX_SRC_HI  = 23;
   localparam int RIX_MIN_CNT = 24;

   function automatic acc_t decode_code(logic [3:0] c);
      acc_t a;
      a = '{valid: 1'b1, wr: 1'b0, tgt: TGT_NONE};
      case (c)
         4'h1: begin a.wr = 1'b1; a.tgt = TGT_PAT; end
         4'h0: begin a.wr = 1'b0; a.tgt = TGT_PAT; end
         4'h3: begin a.wr = 1'b1; a.tgt = TGT_COL; end
         4'h8: begin a.wr = 1'b0; a.tgt = TGT_COL; end
         4'h5: begin a.wr = 1'b1; a.tgt = TGT_VSC; end
         4'h4: begin a.wr = 1'b0; a.tgt = TGT_VSC; end
         default: a.valid = 1'b0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/vctl_regs.sv
module vctl_regs
   import vctl_pkg::*;
#(
   parameter int NUM_REGS = 24,
   parameter int RW       = 8,
   localparam int IW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] idx,
   input  logic [RW-1:0] val,
   output logic          xfer_en,
   output logic [RW-1:0] step,
   output logic [15:0]   xfer_len,
   output logic [21:0]   xfer_src,
   output logic [1:0]    xfer_mode
);

   initial begin : chk_params
      assert (NUM_REGS >= RIX_MIN_CNT && NUM_REGS <= 32 && RW == 8)
         else $error("vctl_regs: bad NUM_REGS/RW");
   end

   logic [RW-1:0] reg_q [NUM_REGS];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_REGS; i++) begin
         if (!rst_n)
            reg_q[i] <= '0;
         else if (we && idx == IW'(i))
            reg_q[i] <= val;
      end
   end

   assign xfer_en   = reg_q[RIX_MODE2][4];
   assign step      = reg_q[RIX_STEP];
   assign xfer_len  = {reg_q[RIX_LEN_HI], reg_q[RIX_LEN_LO]};
   assign xfer_src  = {reg_q[RIX_SRC_HI][5:0], reg_q[RIX_SRC_MID], reg_q[RIX_SRC_LO]};
   assign xfer_mode = reg_q[RIX_SRC_HI][7:6];

   // R1: a write to the step register is visible on the next cycle
   p_step_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IW'(RIX_STEP)) |=> (step == $past(val)));

endmodule

// File: rtl/vctl_cmd.sv
module vctl_cmd
   import vctl_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr,
   input  logic [15:0]   ctl_wdata,
   input  logic          dat_wr,
   input  logic [15:0]   dat_wlo,
   input  logic          dp_busy,
   input  logic          adv,
   input  logic [7:0]    step,
   input  logic          xfer_en,
   input  logic [1:0]    xfer_mode,
   input  logic [15:0]   xfer_len,
   input  logic [21:0]   xfer_src,
   output logic          reg_we,
   output logic [4:0]    reg_idx,
   output logic [7:0]    reg_val,
   output logic [AW-1:0] addr_q,
   output logic [CW-1:0] code_q,
   output logic          armed_q,
   output logic          dma_req,
   output dkind_e        dma_kind,
   output logic [AW-1:0] dma_dst,
   output logic [CW-1:0] dma_code,
   output logic [15:0]   dma_len,
   output logic [21:0]   dma_src,
   output logic [15:0]   dma_fill
);

   initial begin : chk_params
      assert (AW == 16 && CW == 6) else $error("vctl_cmd: AW/CW fixed by word format");
   end

   logic          pend_q;
   logic          is_reg, first, second, xfer_go, fill_go;
   logic [AW-1:0] nxt_addr;
   logic [CW-1:0] nxt_code;

   always_comb begin
      is_reg   = ctl_wr && !pend_q && (ctl_wdata[15:13] == 3'b100);
      first    = ctl_wr && !pend_q && !is_reg;
      second   = ctl_wr && pend_q;
      nxt_addr = addr_q | {ctl_wdata[1:0], 14'b0};
      nxt_code = code_q | {ctl_wdata[7:4], 2'b0};
      xfer_go  = second && xfer_en && (nxt_code[5:4] != 2'b00);
      fill_go  = dat_wr && armed_q && !dp_busy;
   end

   assign reg_we  = is_reg;
   assign reg_idx = ctl_wdata[12:8];
   assign reg_val = ctl_wdata[7:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         addr_q  <= '0;
         code_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         if (first) begin
            addr_q <= {2'b00, ctl_wdata[13:0]};
            code_q <= {4'b0000, ctl_wdata[15:14]};
            pend_q <= 1'b1;
         end else if (second) begin
            addr_q <= nxt_addr;
            code_q <= nxt_code;
            pend_q <= 1'b0;
         end else if (adv) begin
            addr_q <= addr_q + AW'(step);
         end
         if (xfer_go && xfer_mode == 2'd2)
            armed_q <= 1'b1;
         else if (fill_go)
            armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dma_req  <= 1'b0;
         dma_kind <= DK_MEM;
         dma_dst  <= '0;
         dma_code <= '0;
         dma_len  <= '0;
         dma_src  <= '0;
         dma_fill <= '0;
      end else begin
         dma_req <= (xfer_go && xfer_mode != 2'd2) || fill_go;
         if (fill_go) begin
            dma_kind <= DK_FILL;
            dma_dst  <= addr_q;
            dma_code <= code_q;
            dma_fill <= dat_wlo;
            dma_len  <= xfer_len;
            dma_src  <= xfer_src;
         end else if (xfer_go) begin
            dma_kind <= (xfer_mode == 2'd3) ? DK_COPY : DK_MEM;
            dma_dst  <= nxt_addr;
            dma_code <= nxt_code;
            dma_len  <= xfer_len;
            dma_src  <= xfer_src;
         end
      end
   end

   // R3: a second word always closes the command
   p_second_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && pend_q) |=> !pend_q);

   // R4: no request when transfers are disabled
   p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && pend_q && !xfer_en && !fill_go) |=> !dma_req);

   // R5: a fill request consumes the arming
   p_fill_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && dma_kind == DK_FILL) |-> !armed_q);

   // R4: the request is a single-cycle pulse unless a fill follows
   p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && !ctl_wr && !dat_wr) |=> !dma_req);

endmodule

// File: rtl/vctl_dport.sv
module vctl_dport
   import vctl_pkg::*;
#(
   parameter int AW          = 16,
   parameter int PAT_BYTES   = 65536,
   parameter int COL_BYTES   = 128,
   parameter int VSC_BYTES   = 80
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dat_wr,
   input  logic          dat_rd,
   input  logic          dat_wide,
   input  logic [31:0]   dat_wdata,
   input  logic [3:0]    code_lo,
   input  logic [AW-1:0] addr,
   input  logic          fill_armed,
   input  logic [15:0]   mem_rdata,
   output logic          adv,
   output logic          busy_q,
   output logic          mem_we,
   output logic          mem_re,
   output tgt_e          mem_sel,
   output logic [AW-1:0] mem_addr,
   output logic [15:0]   mem_wdata,
   output logic [31:0]   dat_rdata,
   output logic          dat_rvalid
);

   localparam int LW = AW + 1;

   initial begin : chk_params
      assert (PAT_BYTES <= (1 << AW) && COL_BYTES <= (1 << AW) && VSC_BYTES <= (1 << AW))
         else $error("vctl_dport: memory larger than address space");
   end

   function automatic logic [LW-1:0] lim_of(tgt_e t);
      case (t)
         TGT_PAT: return LW'(PAT_BYTES);
         TGT_COL: return LW'(COL_BYTES);
         TGT_VSC: return LW'(VSC_BYTES);
         default: return '0;
      endcase
   endfunction

   acc_t          acc;
   logic          start_wr, start_rd, issue, issue_wr, issue_rd, in_range;
   logic [AW-1:0] ea;
   logic          op_wr_q;
   logic [15:0]   lo_q, hi_q, beat_val;
   logic          rd_live_q, rd_ok_q, rd_last_q, rd_wide_q;

   always_comb begin
      acc      = decode_code(code_lo);
      start_wr = dat_wr && !busy_q && !fill_armed && acc.valid && acc.wr;
      start_rd = dat_rd && !dat_wr && !busy_q && acc.valid && !acc.wr;
      issue_wr = start_wr || (busy_q && op_wr_q);
      issue_rd = start_rd || (busy_q && !op_wr_q);
      issue    = issue_wr || issue_rd;
      ea       = {addr[AW-1:1], 1'b0};
      in_range = {1'b0, ea} < lim_of(acc.tgt);
      beat_val = rd_ok_q ? mem_rdata : 16'h0000;
   end

   assign adv = issue;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         op_wr_q   <= 1'b0;
         lo_q      <= '0;
         mem_we    <= 1'b0;
         mem_re    <= 1'b0;
         mem_sel   <= TGT_PAT;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         busy_q <= (start_wr || start_rd) && dat_wide;
         if (start_wr) begin
            op_wr_q <= 1'b1;
            lo_q    <= dat_wdata[15:0];
         end else if (start_rd) begin
            op_wr_q <= 1'b0;
         end
         mem_we   <= issue_wr && in_range;
         mem_re   <= issue_rd && in_range;
         if (issue) begin
            mem_sel   <= acc.tgt;
            mem_addr  <= ea;
            mem_wdata <= busy_q ? lo_q : (dat_wide ? dat_wdata[31:16] : dat_wdata[15:0]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_live_q  <= 1'b0;
         rd_ok_q    <= 1'b0;
         rd_last_q  <= 1'b0;
         rd_wide_q  <= 1'b0;
         hi_q       <= '0;
         dat_rdata  <= '0;
         dat_rvalid <= 1'b0;
      end else begin
         rd_live_q <= issue_rd;
         rd_ok_q   <= issue_rd && in_range;
         rd_last_q <= issue_rd && !(start_rd && dat_wide);
         rd_wide_q <= busy_q ? 1'b1 : dat_wide;
         dat_rvalid <= rd_live_q && rd_last_q;
         if (rd_live_q && !rd_last_q)
            hi_q <= beat_val;
         if (rd_live_q && rd_last_q)
            dat_rdata <= rd_wide_q ? {hi_q, beat_val} : {16'h0000, beat_val};
      end
   end

   // R6: every beat uses an even address
   p_even_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> !mem_addr[0]);

   // R8: the second beat follows immediately
   p_busy_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q);

   // R9: no strobe beyond the selected memory
   p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> ({1'b0, mem_addr} < lim_of(mem_sel)));

   // R6: never both strobes at once
   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, mem_re}));

endmodule

// File: rtl/vctl_port.sv
module vctl_port
   import vctl_pkg::*;
#(
   parameter int NUM_REGS  = 24,
   parameter int PAT_BYTES = 65536,
   parameter int COL_BYTES = 128,
   parameter int VSC_BYTES = 80,
   parameter int SFW       = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ctl_wr,
   input  logic           ctl_rd,
   input  logic [15:0]    ctl_wdata,
   output logic [15:0]    ctl_rdata,
   input  logic [SFW-1:0] stat_flags,
   input  logic           dat_wr,
   input  logic           dat_rd,
   input  logic           dat_wide,
   input  logic [31:0]    dat_wdata,
   output logic [31:0]    dat_rdata,
   output logic           dat_rvalid,
   output logic           port_busy,
   output logic           mem_we,
   output logic           mem_re,
   output logic [1:0]     mem_sel,
   output logic [15:0]    mem_addr,
   output logic [15:0]    mem_wdata,
   input  logic [15:0]    mem_rdata,
   output logic           dma_req,
   output logic [1:0]     dma_kind,
   output logic [15:0]    dma_dst,
   output logic [5:0]     dma_code,
   output logic [15:0]    dma_len,
   output logic [21:0]    dma_src,
   output logic [15:0]    dma_fill
);

   localparam int AW = 16;
   localparam int CW = 6;

   initial begin : chk_params
      assert (SFW == 10) else $error("vctl_port: status word carries ten flags");
   end

   logic          reg_we, xfer_en, adv, armed;
   logic [4:0]    reg_idx;
   logic [7:0]    reg_val, step;
   logic [1:0]    xfer_mode;
   logic [15:0]   xfer_len;
   logic [21:0]   xfer_src;
   logic [AW-1:0] addr;
   logic [CW-1:0] code;
   dkind_e        kind;
   tgt_e          sel;

   vctl_regs #(.NUM_REGS(NUM_REGS)) u_regs (
      .clk, .rst_n,
      .we(reg_we), .idx(reg_idx), .val(reg_val),
      .xfer_en, .step, .xfer_len, .xfer_src, .xfer_mode
   );

   vctl_cmd #(.AW(AW), .CW(CW)) u_cmd (
      .clk, .rst_n, .ctl_wr, .ctl_wdata,
      .dat_wr, .dat_wlo(dat_wdata[15:0]), .dp_busy(port_busy), .adv, .step,
      .xfer_en, .xfer_mode, .xfer_len, .xfer_src,
      .reg_we, .reg_idx, .reg_val,
      .addr_q(addr), .code_q(code), .armed_q(armed),
      .dma_req, .dma_kind(kind), .dma_dst, .dma_code, .dma_len, .dma_src, .dma_fill
   );

   vctl_dport #(.AW(AW), .PAT_BYTES(PAT_BYTES), .COL_BYTES(COL_BYTES),
                .VSC_BYTES(VSC_BYTES)) u_dport (
      .clk, .rst_n, .dat_wr, .dat_rd, .dat_wide, .dat_wdata,
      .code_lo(code[3:0]), .addr, .fill_armed(armed), .mem_rdata,
      .adv, .busy_q(port_busy), .mem_we, .mem_re, .mem_sel(sel),
      .mem_addr, .mem_wdata, .dat_rdata, .dat_rvalid
   );

   assign dma_kind = kind;
   assign mem_sel  = sel;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_rdata <= '0;
      else if (ctl_rd)
         ctl_rdata <= {{(16-SFW){1'b0}}, stat_flags};
   end

   // R11: status read captures the flags of the read cycle
   p_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd |=> (ctl_rdata == {6'b0, $past(stat_flags)}));

   // R10: a write against a read code never strobes memory
   p_dir_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !port_busy && !armed && !code[0]) |=> !mem_we);

endmodule

// File: tb/vctl_port_bench.sv
module vctl_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 0, ctl_rd = 0, dat_wr = 0, dat_rd = 0, dat_wide = 0;
   logic [15:0] ctl_wdata = '0;
   logic [9:0]  stat_flags = '0;
   logic [31:0] dat_wdata = '0;
   logic [15:0] ctl_rdata, mem_addr, mem_wdata, mem_rdata, dma_dst, dma_len, dma_fill;
   logic [31:0] dat_rdata;
   logic        dat_rvalid, port_busy, mem_we, mem_re, dma_req;
   logic [1:0]  mem_sel, dma_kind;
   logic [5:0]  dma_code;
   logic [21:0] dma_src;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   function automatic logic [15:0] mem_model(logic [1:0] s, logic [15:0] a);
      return {a[15:2], s} ^ 16'h5A3C;
   endfunction

   assign mem_rdata = mem_model(mem_sel, mem_addr);

   vctl_port u_vctl_port (
      .clk, .rst_n, .ctl_wr, .ctl_rd, .ctl_wdata, .ctl_rdata, .stat_flags,
      .dat_wr, .dat_rd, .dat_wide, .dat_wdata, .dat_rdata, .dat_rvalid, .port_busy,
      .mem_we, .mem_re, .mem_sel, .mem_addr, .mem_wdata, .mem_rdata,
      .dma_req, .dma_kind, .dma_dst, .dma_code, .dma_len, .dma_src, .dma_fill
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cw(logic [15:0] w);
      ctl_wr = 1; ctl_wdata = w;
      @(negedge clk);
      ctl_wr = 0;
   endtask

   task automatic dw(logic [31:0] d, logic wide);
      dat_wr = 1; dat_wdata = d; dat_wide = wide;
      @(negedge clk);
      dat_wr = 0; dat_wide = 0;
   endtask

   task automatic dr(logic wide);
      dat_rd = 1; dat_wide = wide;
      @(negedge clk);
      dat_rd = 0; dat_wide = 0;
   endtask

   task automatic t_reset;
      chk("R12", "ctl_rdata", 32'(ctl_rdata), 0);
      chk("R12", "strobes", {29'b0, mem_we, mem_re, dma_req}, 0);
      chk("R12", "busy/rvalid", {30'b0, port_busy, dat_rvalid}, 0);
      cw(16'h4030); cw(16'h0000);          // pattern write, step still 0
      dw(32'h0000_1111, 0);
      chk("R12", "addr first", 32'(mem_addr), 32'h30);
      dw(32'h0000_2222, 0);
      chk("R12", "zero step keeps addr", 32'(mem_addr), 32'h30);
   endtask

   task automatic t_step;
      cw(16'h8F02);
      cw(16'h4011); cw(16'h0000);
      dw(32'h0000_ABCD, 0);
      chk("R6", "we", 32'(mem_we), 1);
      chk("R6", "even addr", 32'(mem_addr), 32'h10);
      chk("R6", "wdata", 32'(mem_wdata), 32'hABCD);
      chk("R6", "sel pattern", 32'(mem_sel), 0);
      dw(32'h0000_0001, 0);
      chk("R1", "step 2", 32'(mem_addr), 32'h12);
   endtask

   task automatic t_second;
      cw(16'h4010); cw(16'h0003);
      dw(32'h0, 0);
      chk("R3", "high addr bits", 32'(mem_addr), 32'hC010);
      cw(16'h8F04);
      cw(16'h4020); cw(16'h8F00);          // second word, not a register write
      dw(32'h0, 0);
      chk("R3", "addr", 32'(mem_addr), 32'h20);
      dw(32'h0, 0);
      chk("R3", "step untouched", 32'(mem_addr), 32'h24);
      cw(16'h8F02);
   endtask

   task automatic t_cram;
      cw(16'hC07E); cw(16'h0000);
      dw(32'h0000_0F0F, 0);
      chk("R6", "colour we", {30'b0, mem_we, 1'b0} | 32'(mem_sel), 32'h3);
      dw(32'h0000_1234, 0);
      chk("R9", "oob write dropped", 32'(mem_we), 0);
      dw(32'h0000_1234, 0);
      chk("R9", "still dropped", 32'(mem_we), 0);
      cw(16'h0000); cw(16'h0020);          // colour read at 0
      dr(0);
      chk("R9", "address kept moving", 32'(mem_addr), 0);
   endtask

   task automatic t_read;
      cw(16'h004E); cw(16'h0010);          // vertical-scroll read
      dr(0);
      chk("R7", "re/sel/addr", {14'b0, mem_re, 1'b0, mem_sel, mem_addr}, {14'b0, 1'b1, 1'b0, 2'd2, 16'h4E});
      @(negedge clk);
      chk("R7", "rvalid", 32'(dat_rvalid), 1);
      chk("R7", "rdata", dat_rdata, 32'(mem_model(2'd2, 16'h4E)));
      dr(0);
      chk("R9", "oob read no strobe", 32'(mem_re), 0);
      @(negedge clk);
      chk("R9", "oob read zero", {31'b0, dat_rvalid} | (dat_rdata << 1), 1);
   endtask

   task automatic t_wide;
      cw(16'h4100); cw(16'h0000);
      dw(32'h1111_2222, 1);
      chk("R8", "beat1", {mem_we, port_busy, mem_addr[13:0], mem_wdata}, {2'b11, 14'h100, 16'h1111});
      @(negedge clk);
      chk("R8", "beat2", {mem_we, port_busy, mem_addr[13:0], mem_wdata}, {2'b10, 14'h102, 16'h2222});
      cw(16'h0010); cw(16'h0020);          // colour read at 0x10
      dr(1);
      chk("R8", "rbeat1", {15'b0, mem_re, mem_addr}, {15'b0, 1'b1, 16'h10});
      @(negedge clk);
      chk("R8", "rbeat2", {15'b0, mem_re, mem_addr}, {15'b0, 1'b1, 16'h12});
      @(negedge clk);
      chk("R8", "wide rdata", dat_rdata, {mem_model(2'd1, 16'h10), mem_model(2'd1, 16'h12)});
   endtask

   task automatic t_mismatch;
      cw(16'h0040); cw(16'h0000);          // pattern read
      dw(32'h0000_5555, 0);
      chk("R10", "no we on read code", {31'b0, mem_we}, 0);
      @(negedge clk);
      chk("R10", "no rvalid", 32'(dat_rvalid), 0);
      dr(0);
      chk("R10", "addr unchanged", 32'(mem_addr), 32'h40);
      cw(16'h4050); cw(16'h0000);          // pattern write
      dr(0);
      chk("R10", "no re on write code", 32'(mem_re), 0);
      @(negedge clk);
      chk("R10", "no read data", 32'(dat_rvalid), 0);
   endtask

   task automatic t_dma;
      cw(16'h8110); cw(16'h9304); cw(16'h9400);
      cw(16'h9512); cw(16'h9634); cw(16'h9701);
      cw(16'h4100); cw(16'h0080);
      chk("R4", "req", 32'(dma_req), 1);
      chk("R4", "dst/code", {10'b0, dma_code, dma_dst}, {10'b0, 6'h21, 16'h0100});
      chk("R4", "len", 32'(dma_len), 4);
      chk("R5", "kind mem + src", {8'b0, dma_kind, dma_src}, {8'b0, 2'd0, 22'h013412});
      @(negedge clk);
      chk("R4", "pulse", 32'(dma_req), 0);
      cw(16'h9741); cw(16'h4100); cw(16'h0080);
      chk("R5", "mode 1 is mem", {29'b0, dma_req, dma_kind}, {29'b0, 1'b1, 2'd0});
      cw(16'h97C0); cw(16'h4100); cw(16'h0080);
      chk("R5", "copy", {29'b0, dma_req, dma_kind}, {29'b0, 1'b1, 2'd2});
      cw(16'h9780); cw(16'h4200); cw(16'h0080);
      chk("R5", "fill waits", 32'(dma_req), 0);
      dw(32'h0000_BEEF, 0);
      chk("R5", "fill req", {13'b0, dma_req, dma_kind, mem_we, dma_fill}, {13'b0, 1'b1, 2'd1, 1'b0, 16'hBEEF});
      chk("R5", "fill dst", 32'(dma_dst), 32'h0200);
      dw(32'h0000_1234, 0);
      chk("R5", "after fill plain write", {15'b0, mem_we, mem_addr}, {15'b0, 1'b1, 16'h0200});
      cw(16'h8100); cw(16'h4100); cw(16'h0080);
      chk("R4", "disabled", 32'(dma_req), 0);
      cw(16'h8110); cw(16'h4100); cw(16'h0000);
      chk("R4", "code 5:4 zero", 32'(dma_req), 0);
      cw(16'h8100);
   endtask

   task automatic t_status;
      stat_flags = 10'h2A5;
      ctl_rd = 1;
      @(negedge clk);
      ctl_rd = 0; stat_flags = 10'h3FF;
      chk("R11", "status", 32'(ctl_rdata), 32'h02A5);
      cw(16'h8F06);                         // register 15 = 6
      cw(16'h4000); cw(16'h0000);
      dw(32'h0, 0); dw(32'h0, 0);
      chk("R1", "register number select", 32'(mem_addr), 32'h6);
      chk("R2", "code from top bits", 32'(mem_sel), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_step;
      t_second;
      t_cram;
      t_read;
      t_wide;
      t_mismatch;
      t_dma;
      t_status;
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule